// File: doc/BRIEF.md
# Serial Control Port Slave

This block is the slave end of a four-wire serial control link in front of an on-chip address space that holds control registers, a parameter RAM and a program RAM. The master frames each transfer with an active-low latch input, clocks bits with a serial clock and sends them most significant bit first on the data input. Each frame opens with a 16-bit header that carries a read/write flag and a 10-bit address. A 24-bit data field follows.

On a write, the block collects the 24 data bits and issues one write beat toward the memories. On a read, it requests the addressed word, loads the returned value into an output shift register and shifts it out on the serial output. The serial output is enabled only while read data is being sent. With burst mode on, any number of words can follow one header, and the address steps up by one after each complete word. With burst mode off, a frame carries exactly one word.

All four serial pins are sampled in the system clock domain through two-stage synchronisers. The serial clock must therefore stay low and high for at least 4 system clock cycles in each phase. The write channel is a valid-only stream with no back-pressure, because a serial master cannot be stalled: the sink must take every beat in the cycle it is offered. A read request expects its data on `rd_data` exactly one cycle after `rd_req`.

Top module: `ctl_serial_slave`

## Requirements
- R1: The header is 16 bits, sampled on serial clock rising edges, MSB first. Header bits 15..11 are zero, bit 10 is the direction (0 = write, 1 = read) and bits 9..0 are the address. A frame is either a write frame or a read frame, never both.
- R2: In a write frame, each completed 24-bit data word (MSB first) produces one single-cycle `wr_valid` pulse carrying the address and the word. The pulse is visible in the third system clock cycle after the serial clock rise that carries the last data bit.
- R3: A frame whose latch is released before a data word is complete issues no write for that word.
- R4: In a read frame, the last header bit produces one single-cycle `rd_req` pulse with `rd_addr` equal to the header address. `rd_data` is taken one cycle after `rd_req`.
- R5: `sdo_oe` stays low during both header bytes, in write frames and while the latch is high. It goes high from the first data bit of a read and drops after the latch is released.
- R6: Read data leaves MSB first. `sdo` changes only after serial clock falling edges, so that every bit is stable at the next rising edge.
- R7: With `burst_en` = 1, the address steps up by one after each complete word, wrapping from 0x3FF to 0x000. For writes, each word is written to the next address. For reads, a new `rd_req` is issued for the next address at each word end.
- R8: With `burst_en` = 0, bits after the first data word are ignored. No further write or read request is made, and `sdo_oe` drops once the word has ended.
- R9: After reset, `wr_valid`, `rd_req`, `sdo` and `sdo_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_en | input | 1 | 1 = several words per frame with address increment |
| latch_n | input | 1 | Active-low frame select from the master |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (valid when sdo_oe is high) |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| wr_valid | output | 1 | Write beat valid (single cycle) |
| wr_addr | output | 10 | Write address |
| wr_data | output | 24 | Write data |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | 10 | Read address |
| rd_data | input | 24 | Read data, valid one cycle after rd_req |

## Verification
A write beat is due three system clocks after the serial clock rise that carries the last bit of a word. The bench drives every pin on the falling system clock edge and counts exactly three falling edges after that rise before it looks at `wr_valid`. A monitor pops the expected write and read-request queues on every clock, so an early, late, repeated or missing beat shows up as a mismatch or as a leftover entry. Serial output bits are sampled just before each serial clock rise, six system clocks after the preceding fall. This leaves room for the roughly four-cycle path through the synchroniser and the shifter, and it also checks the enable during the header and after the latch is released.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 24;
  localparam int HDR_BITS = 16;
  localparam int DIR_BIT  = ADDR_W;
  localparam int CNT_W    = $clog2(DATA_W);

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_t;
endpackage

// File: rtl/csp_sync.sv
module csp_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/csp_rx.sv
module csp_rx
  import csp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_en,
  input  logic              frame_on,
  input  logic              rise,
  input  logic              sdi_bit,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_phase,
  output logic              load_slot
);
  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic [DATA_W-1:0]  sh;
  logic [ADDR_W-1:0]  addr;
  logic               dir_rd;
  logic [DATA_W-1:0]  next_sh;

  assign next_sh   = {sh[DATA_W-2:0], sdi_bit};
  assign rd_addr   = addr;
  assign rd_phase  = (phase == PH_DATA) && dir_rd;
  assign load_slot = rd_phase && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_HDR;
      cnt      <= '0;
      sh       <= '0;
      addr     <= '0;
      dir_rd   <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_req   <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      rd_req   <= 1'b0;
      if (!frame_on) begin
        phase  <= PH_HDR;
        cnt    <= '0;
        dir_rd <= 1'b0;
      end else if (rise) begin
        sh <= next_sh;
        unique case (phase)
          PH_HDR: begin
            if (cnt == CNT_W'(HDR_BITS - 1)) begin
              dir_rd <= next_sh[DIR_BIT];
              addr   <= next_sh[ADDR_W-1:0];
              phase  <= PH_DATA;
              cnt    <= '0;
              rd_req <= next_sh[DIR_BIT];
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_DATA: begin
            if (cnt == CNT_W'(DATA_W - 1)) begin
              cnt <= '0;
              if (!dir_rd) begin
                wr_valid <= 1'b1;
                wr_addr  <= addr;
                wr_data  <= next_sh;
              end
              if (burst_en) begin
                addr   <= addr + 1'b1;
                rd_req <= dir_rd;
              end else begin
                phase <= PH_DONE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |=> !wr_valid && !rd_req);
endmodule

// File: rtl/csp_tx.sv
module csp_tx
  import csp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_on,
  input  logic              fall,
  input  logic              rd_phase,
  input  logic              load_slot,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sdo,
  output logic              sdo_oe
);
  logic              ack_q;
  logic [DATA_W-1:0] pend;
  logic [DATA_W-1:0] osh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      pend  <= '0;
    end else begin
      ack_q <= rd_req;
      if (ack_q) pend <= rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osh    <= '0;
      sdo_oe <= 1'b0;
    end else if (!frame_on || !rd_phase) begin
      sdo_oe <= 1'b0;
    end else if (fall) begin
      if (load_slot) begin
        osh    <= pend;
        sdo_oe <= 1'b1;
      end else begin
        osh <= {osh[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign sdo = sdo_oe & osh[DATA_W-1];

  // R5
  oe_rdonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_phase |=> !sdo_oe);
  // R6
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$past(fall)) |-> $stable(sdo));
endmodule

// File: rtl/ctl_serial_slave.sv
module ctl_serial_slave
  import csp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_en,
  input  logic              latch_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data
);
  logic [2:0] pins_s;
  logic       latch_s, sclk_s, sdi_s, sclk_q;
  logic       frame_on, rise, fall;
  logic       rd_phase, load_slot;

  csp_sync #(.N(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({latch_n, sclk, sdi}),
    .dout (pins_s)
  );

  assign {latch_s, sclk_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  assign frame_on = !latch_s;
  assign rise     = frame_on &  sclk_s & ~sclk_q;
  assign fall     = frame_on & ~sclk_s &  sclk_q;

  csp_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .burst_en (burst_en),
    .frame_on (frame_on),
    .rise     (rise),
    .sdi_bit  (sdi_s),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_phase (rd_phase),
    .load_slot(load_slot)
  );

  csp_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_on (frame_on),
    .fall     (fall),
    .rd_phase (rd_phase),
    .load_slot(load_slot),
    .rd_req   (rd_req),
    .rd_data  (rd_data),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
  );

  // R1
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_req));
  // R5
  latch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_on |=> !sdo_oe);
endmodule

// File: tb/test_ctl_serial_slave.sv
module test_ctl_serial_slave;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        burst_en = 1'b0;
  logic        latch_n = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, sdo_oe, wr_valid, rd_req;
  logic [9:0]  wr_addr, rd_addr;
  logic [23:0] wr_data, rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [33:0] wq[$];
  logic [9:0]  rq[$];
  logic [23:0] wdat [4];

  always #10 clk = ~clk;

  ctl_serial_slave i_ctl_serial_slave (
    .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .latch_n(latch_n),
    .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [23:0] memf(logic [9:0] a);
    return {~a[7:0], 6'h2A, a};
  endfunction

  // Memory model: one-cycle read latency.
  always @(posedge clk) if (rd_req) rd_data <= memf(rd_addr);

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference comparison on every clock.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wr_valid) begin
        if (wq.size() == 0) chk(0, "R2 unexpected write", {wr_addr, wr_data}, 0);
        else begin
          logic [33:0] e;
          e = wq.pop_front();
          chk({wr_addr, wr_data} == e, "R2 write beat", {wr_addr, wr_data}, e);
        end
      end
      if (rd_req) begin
        if (rq.size() == 0) chk(0, "R4 unexpected read request", rd_addr, 0);
        else begin
          logic [9:0] e;
          e = rq.pop_front();
          chk(rd_addr == e, "R4 read address", rd_addr, e);
        end
      end
    end
  end

  task automatic sbit(input logic b, input bit lat, output logic o, output logic oe);
    sdi = b;
    repeat (H) @(negedge clk);
    o = sdo;
    oe = sdo_oe;
    sclk = 1'b1;
    if (lat) begin
      repeat (3) @(negedge clk);
      chk(wr_valid === 1'b1, "R2 write latency", wr_valid, 1);
      repeat (H - 3) @(negedge clk);
    end else begin
      repeat (H) @(negedge clk);
    end
    sclk = 1'b0;
  endtask

  task automatic frame(input bit rd, input logic [9:0] a, input int nbits,
                       input bit burst, input string tag);
    logic [15:0] hdr;
    logic o, oe;
    int full, hoe, dbad, doe_bad, off_bad;
    hdr = {5'b0, rd, a};
    full = nbits / 24;
    hoe = 0; dbad = 0; doe_bad = 0; off_bad = 0;
    burst_en = burst;
    if (!rd) begin
      for (int w = 0; w < full; w++)
        if (burst || w == 0) wq.push_back({10'(a + w), wdat[w]});
    end else begin
      rq.push_back(a);
      if (burst) for (int w = 0; w < full; w++) rq.push_back(10'(a + w + 1));
    end
    latch_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 15; i >= 0; i--) begin
      sbit(hdr[i], 0, o, oe);
      if (oe !== 1'b0) hoe++;
    end
    for (int j = 0; j < nbits; j++) begin
      int w, k;
      logic [23:0] ev;
      w = j / 24;
      k = 23 - (j % 24);
      ev = memf(10'(a + w));
      sbit(rd ? 1'b0 : wdat[w][k], !rd && (j % 24 == 23) && (burst || w == 0), o, oe);
      if (rd && (burst || w == 0)) begin
        if (oe !== 1'b1) doe_bad++;
        if (o !== ev[k]) dbad++;
      end else if (oe !== 1'b0) off_bad++;
    end
    chk(hoe == 0, {tag, " R5 oe low in header"}, hoe, 0);
    if (rd) begin
      chk(dbad == 0, {tag, " R6 read bits"}, dbad, 0);
      chk(doe_bad == 0, {tag, " R5 oe high on data"}, doe_bad, 0);
    end
    chk(off_bad == 0, {tag, " R8 oe low outside data"}, off_bad, 0);
    latch_n = 1'b1;
    repeat (2 * H) @(negedge clk);
    chk(sdo_oe === 1'b0, {tag, " R5 oe off after latch"}, sdo_oe, 0);
    chk(wq.size() == 0, {tag, " R2 R3 pending writes"}, wq.size(), 0);
    chk(rq.size() == 0, {tag, " R4 pending reads"}, rq.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_valid === 1'b0 && rd_req === 1'b0, "R9 reset strobes", {wr_valid, rd_req}, 0);
    chk(sdo_oe === 1'b0 && sdo === 1'b0, "R9 reset output", {sdo_oe, sdo}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    wdat[0] = 24'hA5C3F0; wdat[1] = 24'h123456; wdat[2] = 24'hFEDCBA; wdat[3] = 24'h0F0F0F;
    frame(0, 10'h155, 24, 0, "R1 single write");
    frame(0, 10'h2AA, 48, 0, "R8 single write extra bits");
    frame(0, 10'h0C3, 31, 0, "R3 short write");
    frame(0, 10'h010, 8, 1, "R3 short burst write");
    frame(0, 10'h3FE, 72, 1, "R7 burst write wrap");
    frame(1, 10'h3FF, 24, 0, "R4 single read");
    frame(1, 10'h081, 48, 0, "R8 single read extra bits");
    frame(1, 10'h0FF, 48, 1, "R7 burst read");
    frame(1, 10'h200, 30, 0, "R5 read cut short");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule